// File: doc/BRIEF.md
# Accumulator Shift and Rotate Unit

This block carries out the shift and rotate operations of a small accumulator machine. The machine has an 8-bit accumulator and a one-bit carry flag V. A caller presents the accumulator, V, a 4-bit operation code and a 4-bit shift count, then pulses `start` for one cycle. The unit takes a snapshot of these operands. It then moves the data by one bit position on each clock until the count is used up, and announces the result with a one-cycle `done` pulse.

There are nine operations. They are plain shifts in either direction, shifts through V in either direction, rotates within the accumulator, rotates through the 9-bit ring formed by V above the accumulator, and an arithmetic right shift that copies the sign. A zero count finishes at once. An undefined code also finishes at once and raises `err`. In both cases the operands come back unchanged. While the unit is busy it ignores any new `start`.

Top module: `acc_shift_unit`

## Requirements
- R1: Code 0x0 shifts right and code 0x4 shifts left, once per count. The vacated bit is filled with 0 and V is left unchanged.
- R2: Code 0x1 shifts right through V: V enters bit 7 and bit 0 goes to V. Code 0x5 shifts left through V: V enters bit 0 and bit 7 goes to V.
- R3: Code 0x2 rotates right and code 0x6 rotates left within the 8 accumulator bits. V is left unchanged.
- R4: Code 0x3 rotates right and code 0x7 rotates left through the 9-bit ring {V, accumulator}, where V sits above bit 7.
- R5: Code 0x8 shifts right and copies bit 7 into the vacated top bit. V is left unchanged.
- R6: Suppose `start` is high while the unit is idle, with a count N greater than 0 and a valid code. Then `busy` is high from the next cycle, and `done` is high for exactly one cycle after N further rising edges, with `busy` low at that point.
- R7: A count of 0 with a valid code raises `done` after the accepting edge, with `err` low. The accumulator and V are returned unchanged.
- R8: Codes 0x9 to 0xF raise `done` and `err` together after the accepting edge, whatever the count. The accumulator and V are returned unchanged.
- R9: A `start` pulse that arrives while `busy` is high has no effect on the result or on the timing of the operation in progress.
- R10: After reset, `busy`, `done`, `err`, `acc_out` and `v_out` are all 0.
- R11: `acc_out` and `v_out` keep the last result until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin an operation |
| op | input | 4 | Operation code |
| count | input | 4 | Number of bit positions to move |
| acc_in | input | 8 | Accumulator operand |
| v_in | input | 1 | Carry flag operand |
| acc_out | output | 8 | Resulting accumulator |
| v_out | output | 1 | Resulting carry flag |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| err | output | 1 | Undefined code, pulses with done |

## Verification
Some properties are checked by assertions on every cycle:
- each step keeps V for the plain shifts, rotates and the arithmetic shift, and carries bit 0 into V for the right-going moves through V;
- the top bit is copied on the arithmetic shift;
- the last step always produces `done` with `busy` low;
- zero counts and undefined codes return the operands on the following cycle;
- the result holds while idle.

Other behaviour only the bench scenarios can show:
- whole multi-step results for every code and count, compared against an independent model;
- the exact latency from `start` to `done`;
- that a second `start` injected during an operation leaves both the result and the latency unchanged.

// File: rtl/asu_pkg.sv
package asu_pkg;

  typedef enum logic [3:0] {
    OP_SHR  = 4'h0,
    OP_SHRV = 4'h1,
    OP_ROR  = 4'h2,
    OP_RORV = 4'h3,
    OP_SHL  = 4'h4,
    OP_SHLV = 4'h5,
    OP_ROL  = 4'h6,
    OP_ROLV = 4'h7,
    OP_SRA  = 4'h8
  } asu_op_e;

  localparam logic [3:0] OP_LAST = 4'h8;

  function automatic logic op_is_valid(input logic [3:0] code);
    return code <= OP_LAST;
  endfunction

endpackage

// File: rtl/asu_step.sv
module asu_step #(
  parameter int W = 8
) (
  input  logic [3:0] op,
  input  logic [W:0] cur,   // {v, acc}
  output logic [W:0] nxt
);
  import asu_pkg::*;

  function automatic logic [W:0] move_one(input logic [3:0] code, input logic [W:0] r);
    logic         v;
    logic [W-1:0] a;
    logic [W:0]   res;
    v = r[W];
    a = r[W-1:0];
    case (code)
      OP_SHR:           res = {v, 1'b0, a[W-1:1]};
      OP_SHRV, OP_RORV: res = {a[0], v, a[W-1:1]};
      OP_ROR:           res = {v, a[0], a[W-1:1]};
      OP_SHL:           res = {v, a[W-2:0], 1'b0};
      OP_SHLV, OP_ROLV: res = {a[W-1], a[W-2:0], v};
      OP_ROL:           res = {v, a[W-2:0], a[W-1]};
      OP_SRA:           res = {v, a[W-1], a[W-1:1]};
      default:          res = r;
    endcase
    return res;
  endfunction

  assign nxt = move_one(op, cur);

endmodule

// File: rtl/asu_ctrl.sv
module asu_ctrl #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_bad,
  input  logic [CW-1:0] cnt_in,
  output logic          accept,
  output logic          step_en,
  output logic          last_step,
  output logic          busy,
  output logic          done
);
  logic [CW-1:0] remain;
  logic          quick;

  assign accept    = start & ~busy;
  assign quick     = accept & (op_bad | (cnt_in == '0));
  assign step_en   = busy;
  assign last_step = busy & (remain == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      remain <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        if (quick) begin
          done <= 1'b1;
        end else begin
          busy   <= 1'b1;
          remain <= cnt_in;
        end
      end else if (busy) begin
        remain <= remain - CW'(1);
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    op,
  input  logic [CW-1:0] count,
  input  logic [W-1:0]  acc_in,
  input  logic          v_in,
  output logic [W-1:0]  acc_out,
  output logic          v_out,
  output logic          done,
  output logic          busy,
  output logic          err
);
  import asu_pkg::*;

  logic       accept;
  logic       step_en;
  logic       last_step;
  logic       op_bad;
  logic [3:0] op_q;
  logic [W:0] data_q;
  logic [W:0] data_nxt;

  assign op_bad = ~op_is_valid(op);

  asu_ctrl #(.CW(CW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_bad    (op_bad),
    .cnt_in    (count),
    .accept    (accept),
    .step_en   (step_en),
    .last_step (last_step),
    .busy      (busy),
    .done      (done)
  );

  asu_step #(.W(W)) u_step (
    .op  (op_q),
    .cur (data_q),
    .nxt (data_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      op_q   <= '0;
      err    <= 1'b0;
    end else begin
      err <= accept & op_bad;
      if (accept) begin
        data_q <= {v_in, acc_in};
        op_q   <= op;
      end else if (step_en) begin
        data_q <= data_nxt;
      end
    end
  end

  assign acc_out = data_q[W-1:0];
  assign v_out   = data_q[W];

endmodule

// File: rtl/asu_chk.sv
module asu_chk #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [3:0]    op,
  input logic [CW-1:0] count,
  input logic [W-1:0]  acc_in,
  input logic          v_in,
  input logic [W-1:0]  acc_out,
  input logic          v_out,
  input logic          done,
  input logic          busy,
  input logic          err,
  input logic          accept,
  input logic          step_en,
  input logic          last_step,
  input logic [3:0]    op_q
);
  AST_PLAIN_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (op_q == 4'h0 || op_q == 4'h4) |=> v_out == $past(v_out)); // R1
  AST_THRU_V_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (op_q == 4'h1 || op_q == 4'h3) |=> v_out == $past(acc_out[0]) && acc_out[W-1] == $past(v_out)); // R2
  AST_RING_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (op_q == 4'h5 || op_q == 4'h7) |=> v_out == $past(acc_out[W-1]) && acc_out[0] == $past(v_out)); // R4
  AST_ROT_KEEPS_V: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && (op_q == 4'h2 || op_q == 4'h6) |=> $stable(v_out)); // R3
  AST_SIGN_COPIED: assert property (@(posedge clk) disable iff (!rst_n)
    step_en && op_q == 4'h8 |=> acc_out[W-1] == $past(acc_out[W-1]) && $stable(v_out)); // R5
  AST_LAST_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_step |=> done && !busy); // R6
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R6
  AST_ZERO_COUNT_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    accept && count == '0 && op <= 4'h8 |=> done && !err && acc_out == $past(acc_in) && v_out == $past(v_in)); // R7
  AST_BAD_OP_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op > 4'h8 |=> done && err && acc_out == $past(acc_in) && v_out == $past(v_in)); // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done); // R8
  AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |-> !accept); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !accept |=> $stable(acc_out) && $stable(v_out)); // R11
endmodule

bind acc_shift_unit asu_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
  .acc_in(acc_in), .v_in(v_in), .acc_out(acc_out), .v_out(v_out),
  .done(done), .busy(busy), .err(err), .accept(accept),
  .step_en(step_en), .last_step(last_step), .op_q(op_q)
);

// File: tb/acc_shift_unit_tb.sv
`timescale 1ns/1ps
module acc_shift_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] op = '0;
  logic [3:0] count = '0;
  logic [7:0] acc_in = '0;
  logic       v_in = 1'b0;
  logic [7:0] acc_out;
  logic       v_out, done, busy, err;
  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  acc_shift_unit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .count(count),
    .acc_in(acc_in), .v_in(v_in), .acc_out(acc_out), .v_out(v_out),
    .done(done), .busy(busy), .err(err)
  );

  // bench model: 9-bit value {v, acc}, one position per iteration
  function automatic logic [8:0] model(input logic [3:0] c, input int n, input logic [7:0] a, input logic v);
    logic [8:0] r = {v, a};
    if (c > 4'h8) return r;
    for (int i = 0; i < n; i++) begin
      case (c)
        4'h0: r = {r[8], 1'b0, r[7:1]};
        4'h1, 4'h3: r = {r[0], r[8:1]};
        4'h2: r = {r[8], r[0], r[7:1]};
        4'h4: r = {r[8], r[6:0], 1'b0};
        4'h5, 4'h7: r = {r[7:0], r[8]};
        4'h6: r = {r[8], r[6:0], r[7]};
        default: r = {r[8], r[7], r[7:1]};
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(input logic [3:0] c, input logic [3:0] n);
    if (c > 4'h8) return "R8";
    if (n == 0) return "R7";
    case (c)
      4'h0, 4'h4: return "R1";
      4'h1, 4'h5: return "R2";
      4'h2, 4'h6: return "R3";
      4'h3, 4'h7: return "R4";
      default:    return "R5";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [3:0] n, input logic [7:0] a,
                        input logic v, input bit inject);
    logic [8:0] exp = model(c, n, a, v);
    int lat = 0;
    @(negedge clk);
    start = 1'b1; op = c; count = n; acc_in = a; v_in = v;
    @(posedge clk);
    @(negedge clk);
    if (inject && n != 0 && c <= 4'h8) begin
      // R9: new request while busy
      start = 1'b1; op = ~c; count = ~n; acc_in = ~a; v_in = ~v;
      check("R6", "busy after start", busy, 1);
    end else begin
      start = 1'b0;
    end
    while (!done && lat < 40) begin
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
    start = 1'b0;
    check(tag_of(c, n), "latency", lat, (c > 4'h8) ? 0 : int'(n));
    check(tag_of(c, n), "acc_out", acc_out, exp[7:0]);
    check(tag_of(c, n), "v_out", v_out, exp[8]);
    check(c > 4'h8 ? "R8" : "R6", "err", err, c > 4'h8);
    check("R6", "busy at done", busy, 0);
    if (inject) check("R9", "result after ignored start", {v_out, acc_out}, exp);
    @(negedge clk);
    check("R6", "done single pulse", done, 0);
    check("R11", "hold acc", acc_out, exp[7:0]);
    check("R11", "hold v", v_out, exp[8]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0A1B));
    repeat (3) @(negedge clk);
    check("R10", "busy", busy, 0);
    check("R10", "done", done, 0);
    check("R10", "err", err, 0);
    check("R10", "acc_out", acc_out, 0);
    check("R10", "v_out", v_out, 0);
    rst_n = 1'b1;
    // directed corners
    run_op(4'h0, 4'd3, 8'hF1, 1'b1, 0);   // R1 -> 1E, V=1
    run_op(4'h4, 4'd15, 8'hFF, 1'b0, 0);  // R1 all shifted out
    run_op(4'h1, 4'd1, 8'h01, 1'b1, 0);   // R2 -> 80, V=1
    run_op(4'h5, 4'd2, 8'hC0, 1'b0, 0);   // R2
    run_op(4'h2, 4'd8, 8'hA5, 1'b1, 0);   // R3 full turn
    run_op(4'h6, 4'd1, 8'h81, 1'b0, 0);   // R3
    run_op(4'h3, 4'd9, 8'h3C, 1'b1, 0);   // R4 full 9-bit ring
    run_op(4'h7, 4'd4, 8'h0F, 1'b1, 0);   // R4
    run_op(4'h8, 4'd7, 8'h80, 1'b0, 0);   // R5 -> FF
    run_op(4'h8, 4'd3, 8'h40, 1'b1, 0);   // R5 positive
    run_op(4'h2, 4'd0, 8'h5A, 1'b1, 0);   // R7
    run_op(4'h9, 4'd5, 8'h33, 1'b1, 0);   // R8
    run_op(4'hF, 4'd0, 8'hC3, 1'b0, 0);   // R8
    run_op(4'h3, 4'd5, 8'h96, 1'b0, 1);   // R9
    run_op(4'h8, 4'd1, 8'hB4, 1'b1, 1);   // R9 one-step case
    for (int k = 0; k < 300; k++) begin
      run_op(4'($urandom_range(0, 15)), 4'($urandom_range(0, 15)),
             8'($urandom), 1'($urandom), bit'($urandom_range(0, 3) == 0));
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule